// File: doc/BRIEF.md
# Shared-Write Dual-Read Distributed RAM

This block is a tiny register-file style RAM made of two 16-word by 2-bit arrays that are always written together through one synchronous write port. The write address, write data and a qualified write request are captured on a rising clock edge. The captured request is then committed into both arrays on the following edge, so every array update uses values that were sampled together.

The two arrays differ only in how they are read. The "shared" array is read at the same primary address input that feeds the write address, so it behaves like a single-port RAM. The "split" array is read at its own read address input, so a reader can look anywhere while the writer keeps its address. No multiplexer between the two addresses is needed. Both read paths are combinational.

Memory words are never reset and start unknown. Only the write request path is reset, by an active-low asynchronous reset that the block releases synchronously.

Top module: `lut_dpram`

## Requirements
- R1: One write updates both arrays. After a write of data D at address A has landed, the shared output with `addr`=A and the split output with `raddr`=A both return D.
- R2: A write request is taken only when `we`=1 and `wpe`=1 at the rising edge. The combinations (1,0), (0,1) and (0,0) leave every word of both arrays unchanged.
- R3: A write request sampled at rising edge k is committed at edge k+1. Reads between edge k and edge k+1, including a split read at the address being written, return the old word. The new word is readable from edge k+1 on.
- R4: `sp_rdata` is the shared array word at `addr`. It follows a change of `addr` with no clock edge.
- R5: `dp_rdata` is the split array word at `raddr`, independent of `addr`. It follows a change of `raddr` with no clock edge.
- R6: While `rst_n` is 0, and for the first two rising edges after it returns to 1, no write request is taken. A request already captured is discarded when `rst_n` falls.
- R7: Write requests on consecutive cycles to different addresses all land, each with its own data.
- R8: Array contents are not cleared by reset. Words written before a reset pulse read back unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset for the write request path |
| we | input | 1 | Write enable |
| wpe | input | 1 | Write-port enable, ANDed with `we` |
| addr | input | ADDR_W (4) | Primary address: shared read address and source of the write address |
| wdata | input | DATA_W (2) | Write data |
| raddr | input | ADDR_W (4) | Independent read address of the split array |
| sp_rdata | output | DATA_W (2) | Shared array read data |
| dp_rdata | output | DATA_W (2) | Split array read data |

## Verification
On every cycle the assertions check three things. A committed request implies that both enables were high at its capture edge. The addressed word holds the captured data one edge after a commit. A read output with a steady address does not move across an edge without a commit. The arrays also agree after a common write. Only the bench scenarios can show the following. The commit lands one edge late, so a split read at the address being written sees the old word. Reads follow address changes between edges. Writes are dropped across the reset window. Stored words survive a reset pulse.

// File: rtl/lut_dpram_pkg.sv
package lut_dpram_pkg;

  localparam int unsigned LDP_ADDR_W    = 4;
  localparam int unsigned LDP_DATA_W    = 2;
  localparam int unsigned LDP_RST_STAGE = 2;

  // read port flavours, index of each array in the read bus
  typedef enum int unsigned {
    PORT_SHARED = 0,
    PORT_SPLIT  = 1
  } rd_port_e;

  localparam int unsigned LDP_NUM_RD = 2;

  function automatic int unsigned words_of(input int unsigned aw);
    return 32'd1 << aw;
  endfunction

endpackage

// File: rtl/lut_rst_sync.sv
module lut_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

  // R6
  sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_sync) |-> $past(rst_n));

endmodule

// File: rtl/lut_wr_capture.sv
module lut_wr_capture #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wpe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_q,
  output logic [ADDR_W-1:0] wa_q,
  output logic [DATA_W-1:0] wd_q
);

  logic wr_d;
  logic cap_en;

  always_comb begin
    wr_d   = we & wpe;
    cap_en = wr_d;
  end

  // request flag: the only reset state of the write path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_d;
  end

  // captured address and data, loaded only with a request
  always_ff @(posedge clk) begin
    if (cap_en) begin
      wa_q <= addr;
      wd_q <= wdata;
    end
  end

  // R2
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(we && wpe));

endmodule

// File: rtl/lut_ram_array.sv
module lut_ram_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned WORDS = lut_dpram_pkg::words_of(ADDR_W);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wd;
  end

  assign rdata = mem[ra];

  // R3
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wa)] == $past(wd)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $stable(ra)) |-> $stable(rdata));

endmodule

// File: rtl/lut_dpram.sv
module lut_dpram #(
  parameter int unsigned ADDR_W = lut_dpram_pkg::LDP_ADDR_W,
  parameter int unsigned DATA_W = lut_dpram_pkg::LDP_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wpe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] sp_rdata,
  output logic [DATA_W-1:0] dp_rdata
);

  import lut_dpram_pkg::*;

  localparam int unsigned NUM_RD = LDP_NUM_RD;

  logic              rst_n_sync;
  logic              wr_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  logic [ADDR_W-1:0] ra_sel [NUM_RD];
  logic [DATA_W-1:0] rd_bus [NUM_RD];

  lut_rst_sync #(.STAGES(LDP_RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lut_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (we),
    .wpe   (wpe),
    .addr  (addr),
    .wdata (wdata),
    .wr_q  (wr_q),
    .wa_q  (wa_q),
    .wd_q  (wd_q)
  );

  for (genvar gi = 0; gi < NUM_RD; gi++) begin : g_arr
    if (gi == int'(PORT_SHARED)) begin : g_shared
      assign ra_sel[gi] = addr;
    end else begin : g_split
      assign ra_sel[gi] = raddr;
    end

    lut_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .wr_en (wr_q),
      .wa    (wa_q),
      .wd    (wd_q),
      .ra    (ra_sel[gi]),
      .rdata (rd_bus[gi])
    );
  end

  assign sp_rdata = rd_bus[PORT_SHARED];
  assign dp_rdata = rd_bus[PORT_SPLIT];

  // R1
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(wr_q) && (raddr == $past(wa_q)) && (addr == raddr))
      |-> (dp_rdata == sp_rdata));

endmodule

// File: tb/sim_lut_dpram.sv
module sim_lut_dpram;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       we, wpe;
  logic [3:0] addr, raddr;
  logic [1:0] wdata;
  logic [1:0] sp_rdata, dp_rdata;

  always #10 clk = ~clk;  // 50 MHz

  lut_dpram u0 (
    .clk(clk), .rst_n(rst_n), .we(we), .wpe(wpe), .addr(addr),
    .wdata(wdata), .raddr(raddr), .sp_rdata(sp_rdata), .dp_rdata(dp_rdata)
  );

  typedef struct {
    logic [1:0] sp;
    logic [1:0] dp;
    bit         sp_v;
    bit         dp_v;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [1:0] model [16];
  bit         mvalid [16];
  bit         s1_v, s2_v;
  logic [3:0] s1_a, s2_a;
  logic [1:0] s1_d, s2_d;
  int         hold_cnt;
  int         nvec = 0;
  int         nerr = 0;
  bit         done = 0;

  // driver: one call per clock cycle, inputs set at the falling edge
  task automatic step(input bit r, input bit w, input bit e,
                      input logic [3:0] a, input logic [1:0] d,
                      input logic [3:0] ra, input string tag);
    exp_t x;
    @(negedge clk);
    if (s2_v) begin model[s2_a] = s2_d; mvalid[s2_a] = 1'b1; end
    s2_v = s1_v; s2_a = s1_a; s2_d = s1_d;
    if (!r) begin
      s2_v = 1'b0; s1_v = 1'b0; hold_cnt = 2;
    end else if (hold_cnt > 0) begin
      s1_v = 1'b0; hold_cnt--;
    end else begin
      s1_v = w & e; s1_a = a; s1_d = d;
    end
    rst_n = r; we = w; wpe = e; addr = a; wdata = d; raddr = ra;
    x.sp = model[a]; x.sp_v = mvalid[a];
    x.dp = model[ra]; x.dp_v = mvalid[ra];
    x.tag = tag;
    sb.push_back(x);
  endtask

  // extra mid-cycle address change, no clock edge in between
  task automatic comb_check(input logic [3:0] a, input logic [3:0] ra);
    #7;
    addr = a; raddr = ra;
    #2;
    if (mvalid[a]) begin
      nvec++;
      if (sp_rdata !== model[a]) begin
        nerr++;
        $display("FAIL R4 sp_rdata=%0d expected=%0d addr=%0d", sp_rdata, model[a], a);
      end
    end
    if (mvalid[ra]) begin
      nvec++;
      if (dp_rdata !== model[ra]) begin
        nerr++;
        $display("FAIL R5 dp_rdata=%0d expected=%0d raddr=%0d", dp_rdata, model[ra], ra);
      end
    end
  endtask

  // monitor: pops one expected item per cycle in the low phase
  initial begin
    exp_t x;
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        x = sb.pop_front();
        if (x.sp_v) begin
          nvec++;
          if (sp_rdata !== x.sp) begin
            nerr++;
            $display("FAIL %s sp_rdata=%0d expected=%0d", x.tag, sp_rdata, x.sp);
          end
        end
        if (x.dp_v) begin
          nvec++;
          if (dp_rdata !== x.dp) begin
            nerr++;
            $display("FAIL %s dp_rdata=%0d expected=%0d", x.tag, dp_rdata, x.dp);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; wpe = 1'b0; addr = '0; wdata = '0; raddr = '0;
    s1_v = 0; s2_v = 0; s1_a = '0; s2_a = '0; s1_d = '0; s2_d = '0; hold_cnt = 2;
    for (int i = 0; i < 16; i++) begin model[i] = '0; mvalid[i] = 1'b0; end

    // R6: writes attempted during reset and the release window
    for (int i = 0; i < 3; i++) step(0, 1, 1, 4'(i), 2'd3, 4'(i), "R6");
    for (int i = 0; i < 2; i++) step(1, 1, 1, 4'(i), 2'd3, 4'(i), "R6");
    step(1, 0, 0, 0, 0, 0, "R6");

    // R1/R7: fill all words back to back
    for (int i = 0; i < 16; i++)
      step(1, 1, 1, 4'(i), 2'(i) ^ 2'(i >> 2), 4'(15 - i), "R7");
    step(1, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, "R1");

    // R1/R4/R5: read every word on both ports, different addresses
    for (int i = 0; i < 16; i++)
      step(1, 0, 1, 4'(i), 2'd0, 4'((i + 5) % 16), "R1");

    // R2: partial enables must not write
    step(1, 1, 0, 4'd3, 2'd0, 4'd3, "R2");
    step(1, 0, 1, 4'd3, 2'd1, 4'd3, "R2");
    step(1, 0, 0, 4'd3, 2'd2, 4'd3, "R2");
    step(1, 0, 0, 4'd3, 2'd0, 4'd3, "R2");
    step(1, 0, 0, 4'd3, 2'd0, 4'd3, "R2");

    // R3: write to 7 while reading it on the split port
    step(1, 1, 1, 4'd7, ~model[7], 4'd7, "R3");
    step(1, 0, 0, 4'd2, 2'd0, 4'd7, "R3");
    step(1, 0, 0, 4'd2, 2'd0, 4'd7, "R3");
    step(1, 0, 0, 4'd7, 2'd0, 4'd7, "R3");

    // R7: consecutive writes, different data, then readback
    step(1, 1, 1, 4'd0, 2'd3, 4'd9, "R7");
    step(1, 1, 1, 4'd1, 2'd2, 4'd9, "R7");
    step(1, 1, 1, 4'd2, 2'd1, 4'd9, "R7");
    step(1, 1, 1, 4'd3, 2'd0, 4'd9, "R7");
    step(1, 0, 0, 4'd0, 2'd0, 4'd1, "R7");
    step(1, 0, 0, 4'd2, 2'd0, 4'd3, "R7");
    step(1, 0, 0, 4'd0, 2'd0, 4'd1, "R7");

    // R5/R4: address changes with no clock edge
    step(1, 0, 0, 4'd4, 2'd0, 4'd5, "R5");
    comb_check(4'd6, 4'd12);
    step(1, 0, 0, 4'd8, 2'd0, 4'd10, "R5");
    comb_check(4'd13, 4'd1);

    // R8/R6: reset pulse with a pending write, contents survive
    step(1, 1, 1, 4'd11, ~model[11], 4'd11, "R6");
    step(0, 1, 1, 4'd12, ~model[12], 4'd11, "R6");
    step(0, 0, 0, 4'd0, 2'd0, 4'd11, "R8");
    step(1, 1, 1, 4'd13, ~model[13], 4'd13, "R6");
    step(1, 1, 1, 4'd14, ~model[14], 4'd14, "R6");
    step(1, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 16; i++)
      step(1, 0, 0, 4'(i), 2'd0, 4'(15 - i), "R8");

    step(1, 0, 0, 0, 0, 0, "R8");
    wait (sb.size() == 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule